// File: doc/BRIEF.md
# Program Counter with Circular Return Stack

This block holds the instruction address for a small microcontroller core. It keeps a 13-bit counter, which can address 8K words. Only 2K words of program storage are built, so the block sends just the low 11 bits of the counter to program memory. Any counter value of 0800h or above therefore folds back into the implemented space. On each cycle the counter can step by one, load a jump target, enter a subroutine or return from one, or be forced to the interrupt entry point.

An 8-entry return-address stack works alongside the counter. A subroutine entry or an interrupt acknowledge saves the address that follows the current one. Any kind of return restores the most recent saved address. The stack is a ring. A ninth save overwrites the oldest entry, and a restore from an empty stack still returns the entry just below the pointer. Neither case is a fault. The block flags both, along with the empty and full states, so that a test environment can observe them.

Instruction decode, program storage and interrupt arbitration sit outside this block and drive its control inputs.

Top module: `prog_counter_top`

## Requirements
- R1: Asserting `rst_n` low clears the counter to 0000h at once, without a clock. It also empties the stack, clears every stack entry to 0000h, and drops both event flags. Release takes effect through a two-stage synchronizer.
- R2: With only `incr_en` active, the counter advances by one per cycle. The 13-bit count wraps from 1FFFh to 0000h.
- R3: `fetch_addr` always equals bits 10:0 of the counter, so 0805h fetches from 005h and 0FFFh fetches from 7FFh.
- R4: With `jump_en` as the winning control, the counter loads `jump_tgt` and the stack is unchanged.
- R5: With `call_en` as the winning control, the counter plus one (13-bit) is pushed and the counter loads `call_tgt`.
- R6: With `ret_en` as the winning control, the most recent stack entry is popped into the counter, in last-in first-out order.
- R7: With `int_ack` active, the counter plus one is pushed and the counter loads 0004h.
- R8: When several controls are active together, only one takes effect. The order is reset, then `int_ack`, then `call_en`, then `ret_en`, then `jump_en`, then `incr_en`. With none active, the counter holds.
- R9: While `stall` is high, the counter, the stack and all four status outputs hold their values, whatever the other controls do.
- R10: A push while the stack holds 8 entries overwrites the oldest entry. The count stays at 8, and `stk_ovf` is high for the cycle after that push.
- R11: A pop from an empty stack returns the entry just below the pointer (the ring wraps). The stack stays empty, and `stk_unf` is high for the cycle after that pop.
- R12: `stk_empty` is high exactly when the stack holds 0 entries, and `stk_full` is high exactly when it holds 8. Each event flag drops on the next cycle that is not stalled and does not repeat its event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freeze all state this cycle |
| incr_en | input | 1 | Step the counter by one |
| jump_en | input | 1 | Load the jump target |
| jump_tgt | input | 13 | Jump target address |
| call_en | input | 1 | Push return address and load call target |
| call_tgt | input | 13 | Subroutine entry address |
| ret_en | input | 1 | Pop the stack into the counter (any return kind) |
| int_ack | input | 1 | Push return address and enter the interrupt vector |
| fetch_addr | output | 11 | Folded program memory address |
| stk_empty | output | 1 | Stack holds no entries |
| stk_full | output | 1 | Stack holds 8 entries |
| stk_ovf | output | 1 | Previous operation pushed onto a full stack |
| stk_unf | output | 1 | Previous operation popped an empty stack |

## Verification
The assertions check these properties on every cycle:
- a stall freezes every output;
- the interrupt vector, call targets and jump targets land on the folded fetch address;
- empty and full never appear together;
- each event flag appears only alongside the matching level flag.

Some behaviour only the bench's scenarios can show. This covers the exact return addresses through a full ring, including which entry an overflow destroyed and the value an underflowing pop yields. It also covers the 13-bit wrap of the counter and the immediate effect of an asynchronous reset. The bench checks these against a reference model of the counter and ring, under both directed sequences and seeded random control mixes.

// File: rtl/prog_counter_pkg.sv
package prog_counter_pkg;

  // Winning operation for one cycle, after priority resolution.
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_INCR = 3'd1,
    OP_JUMP = 3'd2,
    OP_RET  = 3'd3,
    OP_CALL = 3'd4,
    OP_INT  = 3'd5
  } pc_op_e;

endpackage

// File: rtl/pc_reset_sync.sv
module pc_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/pc_op_arbiter.sv
module pc_op_arbiter
  import prog_counter_pkg::*;
(
  input  logic   stall,
  input  logic   int_ack,
  input  logic   call_en,
  input  logic   ret_en,
  input  logic   jump_en,
  input  logic   incr_en,
  output pc_op_e op
);

  always_comb begin
    op = OP_HOLD;
    if (!stall) begin
      if (int_ack)      op = OP_INT;
      else if (call_en) op = OP_CALL;
      else if (ret_en)  op = OP_RET;
      else if (jump_en) op = OP_JUMP;
      else if (incr_en) op = OP_INCR;
    end
  end

endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
  parameter int ADDR_W = 13,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] push_data,
  output logic [ADDR_W-1:0] top_data,
  output logic              empty,
  output logic              full,
  output logic              ovf_evt,
  output logic              unf_evt
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] entry_q [DEPTH];
  logic [PTR_W-1:0]  sp_q, sp_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ovf_q, ovf_d;
  logic              unf_q, unf_d;
  logic [PTR_W-1:0]  sp_inc, sp_dec;

  assign sp_inc = (sp_q == LAST_IDX) ? '0 : sp_q + 1'b1;
  assign sp_dec = (sp_q == '0) ? LAST_IDX : sp_q - 1'b1;

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CNT_MAX);
  assign top_data = entry_q[sp_dec];
  assign ovf_evt  = ovf_q;
  assign unf_evt  = unf_q;

  // Next-state for pointer, occupancy and event flags.
  always_comb begin
    sp_d  = sp_q;
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    unf_d = unf_q;
    if (!hold) begin
      ovf_d = push && full;
      unf_d = pop && empty;
      if (push) begin
        sp_d = sp_inc;
        if (!full) cnt_d = cnt_q + 1'b1;
      end else if (pop) begin
        sp_d = sp_dec;
        if (!empty) cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      sp_q  <= sp_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  // One register per ring slot, written when the pointer selects it.
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic slot_we;
    assign slot_we = !hold && push && (sp_q == PTR_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       entry_q[gi] <= '0;
      else if (slot_we) entry_q[gi] <= push_data;
    end
  end

endmodule

// File: rtl/prog_counter_top.sv
module prog_counter_top
  import prog_counter_pkg::*;
#(
  parameter int              PC_W      = 13,
  parameter int              IMPL_W    = 11,
  parameter int              STK_DEPTH = 8,
  parameter logic [PC_W-1:0] RESET_VEC = 13'h0000,
  parameter logic [PC_W-1:0] INT_VEC   = 13'h0004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              incr_en,
  input  logic              jump_en,
  input  logic [PC_W-1:0]   jump_tgt,
  input  logic              call_en,
  input  logic [PC_W-1:0]   call_tgt,
  input  logic              ret_en,
  input  logic              int_ack,
  output logic [IMPL_W-1:0] fetch_addr,
  output logic              stk_empty,
  output logic              stk_full,
  output logic              stk_ovf,
  output logic              stk_unf
);

  logic            rst_sync_n;
  pc_op_e          op;
  logic [PC_W-1:0] pc_q, pc_d, pc_inc, stk_top;
  logic            do_push, do_pop;

  pc_reset_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pc_op_arbiter u_arb (
    .stall   (stall),
    .int_ack (int_ack),
    .call_en (call_en),
    .ret_en  (ret_en),
    .jump_en (jump_en),
    .incr_en (incr_en),
    .op      (op)
  );

  assign pc_inc  = pc_q + 1'b1;
  assign do_push = (op == OP_INT) || (op == OP_CALL);
  assign do_pop  = (op == OP_RET);

  pc_ret_stack #(
    .ADDR_W (PC_W),
    .DEPTH  (STK_DEPTH)
  ) u_stack (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .hold      (stall),
    .push      (do_push),
    .pop       (do_pop),
    .push_data (pc_inc),
    .top_data  (stk_top),
    .empty     (stk_empty),
    .full      (stk_full),
    .ovf_evt   (stk_ovf),
    .unf_evt   (stk_unf)
  );

  always_comb begin
    unique case (op)
      OP_INT:  pc_d = INT_VEC;
      OP_CALL: pc_d = call_tgt;
      OP_RET:  pc_d = stk_top;
      OP_JUMP: pc_d = jump_tgt;
      OP_INCR: pc_d = pc_inc;
      default: pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pc_q <= RESET_VEC;
    else             pc_q <= pc_d;
  end

  assign fetch_addr = pc_q[IMPL_W-1:0];

endmodule

// File: rtl/prog_counter_sva.sv
module prog_counter_sva #(
  parameter int                IMPL_W = 11,
  parameter logic [IMPL_W-1:0] INT_LO = 11'h004
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              stall,
  input logic              int_ack,
  input logic              call_en,
  input logic              ret_en,
  input logic              jump_en,
  input logic [IMPL_W-1:0] call_lo,
  input logic [IMPL_W-1:0] jump_lo,
  input logic [IMPL_W-1:0] fetch_addr,
  input logic              stk_empty,
  input logic              stk_full,
  input logic              stk_ovf,
  input logic              stk_unf
);

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stall |=> ($stable(fetch_addr) && $stable(stk_empty) && $stable(stk_full)
               && $stable(stk_ovf) && $stable(stk_unf))); // R9

  AST_INT_VECTOR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!stall && int_ack) |=> (fetch_addr == INT_LO)); // R7

  AST_INT_SAVES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!stall && int_ack) |=> !stk_empty); // R7

  AST_CALL_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!stall && !int_ack && call_en) |=> (fetch_addr == $past(call_lo) && !stk_empty)); // R5

  AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!stall && !int_ack && !call_en && !ret_en && jump_en)
      |=> (fetch_addr == $past(jump_lo))); // R4

  AST_LEVELS_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(stk_empty && stk_full)); // R12

  AST_OVF_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stk_ovf |-> stk_full); // R10

  AST_UNF_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stk_unf |-> stk_empty); // R11

endmodule

bind prog_counter_top prog_counter_sva #(
  .IMPL_W (IMPL_W),
  .INT_LO (INT_VEC[IMPL_W-1:0])
) u_sva (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .stall      (stall),
  .int_ack    (int_ack),
  .call_en    (call_en),
  .ret_en     (ret_en),
  .jump_en    (jump_en),
  .call_lo    (call_tgt[IMPL_W-1:0]),
  .jump_lo    (jump_tgt[IMPL_W-1:0]),
  .fetch_addr (fetch_addr),
  .stk_empty  (stk_empty),
  .stk_full   (stk_full),
  .stk_ovf    (stk_ovf),
  .stk_unf    (stk_unf)
);

// File: tb/prog_counter_top_tb_top.sv
`timescale 1ns/1ps
module prog_counter_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic        stall, incr_en, jump_en, call_en, ret_en, int_ack;
  logic [12:0] jump_tgt, call_tgt;
  logic [10:0] fetch_addr;
  logic        stk_empty, stk_full, stk_ovf, stk_unf;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  // Reference model state
  logic [12:0] m_pc;
  logic [12:0] m_stk [8];
  int          m_sp;
  int          m_cnt;
  logic        m_ovf, m_unf;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  prog_counter_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .incr_en    (incr_en),
    .jump_en    (jump_en),
    .jump_tgt   (jump_tgt),
    .call_en    (call_en),
    .call_tgt   (call_tgt),
    .ret_en     (ret_en),
    .int_ack    (int_ack),
    .fetch_addr (fetch_addr),
    .stk_empty  (stk_empty),
    .stk_full   (stk_full),
    .stk_ovf    (stk_ovf),
    .stk_unf    (stk_unf)
  );

  task automatic model_reset();
    m_pc = 13'h0000; m_sp = 0; m_cnt = 0; m_ovf = 0; m_unf = 0;
    for (int i = 0; i < 8; i++) m_stk[i] = 13'h0000;
  endtask

  task automatic model_push(input logic [12:0] v);
    m_ovf = (m_cnt == 8);
    m_stk[m_sp] = v;
    m_sp = (m_sp + 1) % 8;
    if (m_cnt < 8) m_cnt++;
  endtask

  task automatic model_step();
    if (stall) return;
    m_ovf = 0; m_unf = 0;
    if (int_ack) begin
      model_push(m_pc + 13'd1); m_pc = 13'h0004;
    end else if (call_en) begin
      model_push(m_pc + 13'd1); m_pc = call_tgt;
    end else if (ret_en) begin
      m_unf = (m_cnt == 0);
      m_sp = (m_sp + 7) % 8;
      m_pc = m_stk[m_sp];
      if (m_cnt > 0) m_cnt--;
    end else if (jump_en) begin
      m_pc = jump_tgt;
    end else if (incr_en) begin
      m_pc = m_pc + 13'd1;
    end
  endtask

  function automatic logic [14:0] exp_vec();
    return {m_pc[10:0], m_cnt == 0, m_cnt == 8, m_ovf, m_unf};
  endfunction

  task automatic check_all(input string req);
    logic [14:0] act, exp;
    act = {fetch_addr, stk_empty, stk_full, stk_ovf, stk_unf};
    exp = exp_vec();
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: {fetch,empty,full,ovf,unf} actual=%h expected=%h at %0t",
               req, act, exp, $time);
    end
  endtask

  task automatic set_idle();
    stall = 0; incr_en = 0; jump_en = 0; call_en = 0; ret_en = 0; int_ack = 0;
    jump_tgt = '0; call_tgt = '0;
  endtask

  // Called at a falling edge with inputs already set; checks after next edge.
  task automatic cycle(input string req);
    model_step();
    @(negedge clk);
    check_all(req);
    set_idle();
  endtask

  task automatic do_jump(input logic [12:0] t, input string req);
    jump_en = 1; jump_tgt = t; cycle(req);
  endtask

  task automatic do_call(input logic [12:0] t, input string req);
    call_en = 1; call_tgt = t; cycle(req);
  endtask

  task automatic do_ret(input string req);
    ret_en = 1; cycle(req);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 0;
    model_reset();
    #1;
    check_all("R1");
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check_all("R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    set_idle();
    rst_n = 0;
    model_reset();
    repeat (2) @(negedge clk);
    check_all("R1");
    rst_n = 1;
    repeat (3) @(negedge clk);
    check_all("R1");

    // R2 increment
    repeat (3) begin incr_en = 1; cycle("R2"); end
    // R3/R4 folding and jump
    do_jump(13'h0805, "R3");
    do_jump(13'h1FFF, "R4");
    incr_en = 1; cycle("R2");            // 1FFF -> 0000
    do_jump(13'h0FFF, "R3");             // fetch 7FF
    incr_en = 1; cycle("R3");            // 1000 -> fetch 000
    // R5 call, R7 interrupt, R6 returns
    do_call(13'h0123, "R5");
    int_ack = 1; cycle("R7");
    do_ret("R6");
    do_ret("R6");
    // R8 priority
    int_ack = 1; call_en = 1; ret_en = 1; jump_en = 1; incr_en = 1;
    call_tgt = 13'h0222; jump_tgt = 13'h0333; cycle("R8");
    call_en = 1; ret_en = 1; jump_en = 1; incr_en = 1;
    call_tgt = 13'h0444; jump_tgt = 13'h0555; cycle("R8");
    ret_en = 1; jump_en = 1; incr_en = 1; jump_tgt = 13'h0666; cycle("R8");
    jump_en = 1; incr_en = 1; jump_tgt = 13'h0777; cycle("R8");
    cycle("R8");                         // nothing active: hold
    // R9 stall
    stall = 1; int_ack = 1; call_en = 1; ret_en = 1; jump_en = 1; incr_en = 1;
    call_tgt = 13'h0111; cycle("R9");
    stall = 1; ret_en = 1; cycle("R9");

    // R10/R11/R12 ring behaviour from a clean state
    apply_reset();
    for (int i = 0; i < 9; i++) begin
      do_call(13'h0100 + 13'(i * 16), (i == 8) ? "R10" : "R12");
    end
    stall = 1; cycle("R9");              // overflow flag held during stall
    incr_en = 1; cycle("R12");           // overflow flag drops
    for (int i = 0; i < 8; i++) do_ret("R10");
    do_ret("R11");                       // pop while empty
    do_ret("R11");
    incr_en = 1; cycle("R12");

    // Random mix against the reference model
    for (int n = 0; n < 3000; n++) begin
      stall    = ($urandom_range(0, 9) == 0);
      int_ack  = ($urandom_range(0, 19) == 0);
      call_en  = ($urandom_range(0, 5) == 0);
      ret_en   = ($urandom_range(0, 5) == 0);
      jump_en  = ($urandom_range(0, 7) == 0);
      incr_en  = ($urandom_range(0, 1) == 0);
      jump_tgt = 13'($urandom);
      call_tgt = 13'($urandom);
      cycle("R8");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule